// File: doc/BRIEF.md
# External Edge Port Interrupt Unit

This block turns a group of external interrupt pins into interrupt requests for a downstream interrupt controller. Pin positions run from 1 to `NUM_PINS-1`. Position 0 is a reserved placeholder: it reads as zero and ignores writes. Each pin passes through a two-flop synchronizer. A detector then checks it against the trigger mode chosen for that pin: low level, rising edge, falling edge or either edge.

Edge events are captured in sticky flag bits, which software clears by writing 1. A pin in level mode does not latch: its flag view and its request follow the synchronized pin, which is active low. Each pin's request line is its enable bit ANDed with its flag (edge modes) or with its level condition (level mode).

Software reaches four registers through a single-cycle write port and a combinational read port. The registers are trigger mode, direction, enable and flag. Each register reads back exactly what it holds, so software can do read-modify-write on a single pin's field. The direction bits go to the pad logic, where a cleared bit makes the pin an input. An internal synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset every register reads zero, so all pins are inputs in level mode and disabled, and `irq_req` and `dir_out` are zero. Bit position 0 of every register, of `dir_out` and of `irq_req` always stays zero.
- R2: `reg_sel` selects the register: 0 = trigger mode (16 bits, field of pin n at bits [2n+1:2n]), 1 = direction, 2 = enable, 3 = flag. The byte registers use bit n for pin n and read with the upper byte zero. A read returns the stored value, so a read-modify-write of one field leaves every other field unchanged.
- R3: Trigger code 2'b01 (rising) sets the pin's flag on a low-to-high transition of the synchronized pin.
- R4: Trigger code 2'b10 (falling) sets the flag on a high-to-low transition and ignores rising transitions.
- R5: Trigger code 2'b11 (both) sets the flag on either transition.
- R6: A write to the flag register clears exactly the edge-mode flags whose data bit is 1. Bits written as 0 leave their flags unchanged. An edge flag otherwise stays set.
- R7: With trigger code 2'b00 (level), the flag view of the pin reads 1 while the synchronized pin is low and 0 while it is high. Nothing is latched, and a flag-clear write has no effect.
- R8: `irq_req[n]` is 1 only when enable bit n is set and pin n's flag view is 1. A flag latches even when its pin is disabled, but that pin raises no request.
- R9: `dir_out` shows the direction register and changes only on a write to it.
- R10: An edge on `pin_in` shows in the flag on the third rising clock edge after the pin changes and not before: two synchronizer stages, then one edge-compare stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 2 | Register select (0 mode, 1 direction, 2 enable, 3 flag) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| pin_in | input | 8 | External interrupt pins (bit 0 reserved) |
| dir_out | output | 8 | Direction per pin, 1 = output |
| irq_req | output | 8 | Interrupt request per pin |

## Verification
The bench places edges exactly, to check the three-edge latency. A design with one synchronizer stage too few or too many would show the flag one cycle early or late. It clears one flag while a neighbour is set and writes zeros to the flag register. A clear decoded as a full write, or as a toggle, would wipe out or flip the neighbour. It then gives the falling mode a rising edge and the level mode a clear write. A detector with swapped modes would latch the wrong transition, and a level pin that latched would keep requesting after the pin returned high. Further checks cover writes to the reserved position 0, a read-modify-write of one mode field, and a disabled pin with a pending flag. These catch mask errors and a request that ignores the enable.

// File: rtl/eport_pkg.sv
`timescale 1ns/1ps
package eport_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_FLAG = 2'd3
  } regsel_e;

endpackage

// File: rtl/eport_rst_sync.sv
`timescale 1ns/1ps
module eport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_int_n = stage_q[1];

endmodule

// File: rtl/eport_sync.sv
`timescale 1ns/1ps
module eport_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        stab_q <= meta_q;
      end
    end

    assign sync_out[i] = stab_q;
  end

endmodule

// File: rtl/eport_detect.sv
`timescale 1ns/1ps
module eport_detect
  import eport_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_s,
  input  logic [MODE_W-1:0]   mode_q,
  output logic [NUM_PINS-1:0] edge_hit,
  output logic [NUM_PINS-1:0] level_act
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] prev_d;

  always_comb begin
    prev_d = pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise;
    logic fall;
    trig_e trig;

    always_comb begin
      trig = trig_e'(mode_q[2*i +: 2]);
      rise = pin_s[i] & ~prev_q[i];
      fall = ~pin_s[i] & prev_q[i];
      case (trig)
        TRIG_RISE: edge_hit[i] = rise;
        TRIG_FALL: edge_hit[i] = fall;
        TRIG_BOTH: edge_hit[i] = rise | fall;
        default:   edge_hit[i] = 1'b0;
      endcase
      level_act[i] = ~pin_s[i];
    end
  end

endmodule

// File: rtl/eport_regs.sv
`timescale 1ns/1ps
module eport_regs
  import eport_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [MODE_W-1:0]   reg_wdata,
  output logic [MODE_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] edge_hit,
  input  logic [NUM_PINS-1:0] level_act,
  output logic [MODE_W-1:0]   mode_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] ien_q,
  output logic [NUM_PINS-1:0] flag_q,
  output logic [NUM_PINS-1:0] flag_view
);

  localparam logic [NUM_PINS-1:0] PIN_MASK  = {{(NUM_PINS-1){1'b1}}, 1'b0};
  localparam logic [MODE_W-1:0]   MODE_MASK = {{(MODE_W-2){1'b1}}, 2'b00};

  logic                mode_en, dir_en, ien_en, clr_en;
  logic [MODE_W-1:0]   mode_d;
  logic [NUM_PINS-1:0] dir_d, ien_d, flag_d;
  logic [NUM_PINS-1:0] is_level;

  always_comb begin
    mode_en = reg_wr && (reg_sel == SEL_MODE);
    dir_en  = reg_wr && (reg_sel == SEL_DIR);
    ien_en  = reg_wr && (reg_sel == SEL_IEN);
    clr_en  = reg_wr && (reg_sel == SEL_FLAG);
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lvl
    assign is_level[i] = (mode_q[2*i +: 2] == TRIG_LEVEL);
  end

  always_comb begin
    mode_d = mode_en ? (reg_wdata & MODE_MASK) : mode_q;
    dir_d  = dir_en  ? (reg_wdata[NUM_PINS-1:0] & PIN_MASK) : dir_q;
    ien_d  = ien_en  ? (reg_wdata[NUM_PINS-1:0] & PIN_MASK) : ien_q;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (is_level[i])                    flag_d[i] = 1'b0;
      else if (edge_hit[i])               flag_d[i] = 1'b1;
      else if (clr_en && reg_wdata[i])    flag_d[i] = 1'b0;
      else                                flag_d[i] = flag_q[i];
    end
    flag_d = flag_d & PIN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      flag_view[i] = is_level[i] ? level_act[i] : flag_q[i];
    end
    flag_view = flag_view & PIN_MASK;
  end

  always_comb begin
    case (reg_sel)
      SEL_MODE: reg_rdata = mode_q;
      SEL_DIR:  reg_rdata = {{(MODE_W-NUM_PINS){1'b0}}, dir_q};
      SEL_IEN:  reg_rdata = {{(MODE_W-NUM_PINS){1'b0}}, ien_q};
      default:  reg_rdata = {{(MODE_W-NUM_PINS){1'b0}}, flag_view};
    endcase
  end

endmodule

// File: rtl/edge_irq_unit.sv
`timescale 1ns/1ps
module edge_irq_unit #(
  parameter int NUM_PINS = 8,
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [MODE_W-1:0]   reg_wdata,
  output logic [MODE_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] dir_out,
  output logic [NUM_PINS-1:0] irq_req
);

  logic                rst_int_n;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] level_act;
  logic [MODE_W-1:0]   mode_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] ien_q;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] flag_view;

  eport_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  eport_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  eport_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_s     (pin_s),
    .mode_q    (mode_q),
    .edge_hit  (edge_hit),
    .level_act (level_act)
  );

  eport_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .edge_hit  (edge_hit),
    .level_act (level_act),
    .mode_q    (mode_q),
    .dir_q     (dir_q),
    .ien_q     (ien_q),
    .flag_q    (flag_q),
    .flag_view (flag_view)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_req
    assign irq_req[i] = ien_q[i] & flag_view[i];
  end

  assign dir_out = dir_q;

endmodule

// File: rtl/eport_chk.sv
`timescale 1ns/1ps
module eport_chk #(
  parameter int NUM_PINS = 8,
  localparam int MODE_W  = 2 * NUM_PINS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [1:0]          reg_sel,
  input logic [NUM_PINS-1:0] wdata_lo,
  input logic [NUM_PINS-1:0] dir_out,
  input logic [NUM_PINS-1:0] irq_req,
  input logic [NUM_PINS-1:0] ien_q,
  input logic [MODE_W-1:0]   mode_q,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] pin_s
);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~ien_q) == '0);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req[0] == 1'b0) && (dir_out[0] == 1'b0) && (flag_q[0] == 1'b0));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel == 2'd1) |=> $stable(dir_out));

  for (genvar i = 1; i < NUM_PINS; i++) begin : g_pin
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && (mode_q[2*i +: 2] != 2'b00)
       && !(reg_wr && reg_sel == 2'd3 && wdata_lo[i])
       && !(reg_wr && reg_sel == 2'd0)) |=> flag_q[i]);

    // R7
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*i +: 2] == 2'b00) |-> (irq_req[i] == (ien_q[i] & ~pin_s[i])));
  end

endmodule

bind edge_irq_unit eport_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .wdata_lo (reg_wdata[NUM_PINS-1:0]),
  .dir_out  (dir_out),
  .irq_req  (irq_req),
  .ien_q    (ien_q),
  .mode_q   (mode_q),
  .flag_q   (flag_q),
  .pin_s    (pin_s)
);

// File: tb/edge_irq_unit_tb_top.sv
`timescale 1ns/1ps
module edge_irq_unit_tb_top;

  localparam int NP = 8;
  localparam int MW = 2 * NP;
  localparam int NVEC = 8;

  // entry: {sel[1:0], wdata[15:0], expected readback[15:0]}  (R2, R9, R1)
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd0, 16'hFFFF, 16'hFFFC},
    {2'd0, 16'h1234, 16'h1234},
    {2'd1, 16'h00FF, 16'h00FE},
    {2'd1, 16'h0055, 16'h0054},
    {2'd2, 16'hFFA3, 16'h00A2},
    {2'd2, 16'h0000, 16'h0000},
    {2'd0, 16'h0000, 16'h0000},
    {2'd1, 16'h0000, 16'h0000}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_sel;
  logic [MW-1:0] reg_wdata;
  logic [MW-1:0] reg_rdata;
  logic [NP-1:0] pins;
  logic [NP-1:0] dir_out;
  logic [NP-1:0] irq_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_unit #(.NUM_PINS(NP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pins),
    .dir_out   (dir_out),
    .irq_req   (irq_req)
  );

  task automatic check(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [MW-1:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [MW-1:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] v;
    logic [15:0] msh;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0; pins = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      check("R1 reset reg", v, '0);
    end
    check("R1 reset irq", {8'h00, irq_req}, '0);
    check("R1 reset dir", {8'h00, dir_out}, '0);

    // Vector table: write then read back (R2, R9)
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][33:32], VEC[k][31:16]);
      rd(VEC[k][33:32], v);
      check("R2 readback", v, VEC[k][15:0]);
      if (VEC[k][33:32] == 2'd1)
        check("R9 dir_out", {8'h00, dir_out}, VEC[k][15:0]);
    end

    // R2 read-modify-write of pin 3 field
    wr(2'd0, 16'hA5A4);
    rd(2'd0, v);
    v = (v & ~16'h00C0) | 16'h0040;
    wr(2'd0, v);
    rd(2'd0, v);
    check("R2 rmw field", v, 16'hA564);
    wr(2'd0, 16'h0000);

    // R10 / R3 rising on pin 1 with exact latency
    pins[1] = 1'b0;
    settle();
    msh = 16'h0004;
    wr(2'd0, msh);
    pins[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd3, v);
    check("R10 not yet", v, 16'h0000);
    @(negedge clk);
    rd(2'd3, v);
    check("R10 R3 rise flag", v, 16'h0002);
    check("R8 disabled no irq", {8'h00, irq_req}, 16'h0000);
    wr(2'd2, 16'h0002);
    check("R8 enabled irq", {8'h00, irq_req}, 16'h0002);

    // R6 selective clear
    msh = 16'h0054;
    wr(2'd0, msh);
    pins[3:2] = 2'b00;
    settle();
    pins[3:2] = 2'b11;
    settle();
    rd(2'd3, v);
    check("R6 three flags", v, 16'h000E);
    wr(2'd3, 16'h0004);
    rd(2'd3, v);
    check("R6 clear one", v, 16'h000A);
    wr(2'd3, 16'h0000);
    rd(2'd3, v);
    check("R6 zero write", v, 16'h000A);
    wr(2'd3, 16'h000A);
    rd(2'd3, v);
    check("R6 clear rest", v, 16'h0000);
    check("R8 irq drops", {8'h00, irq_req}, 16'h0000);

    // R4 falling on pin 4
    msh = msh | 16'h0200;
    wr(2'd0, msh);
    pins[4] = 1'b0;
    settle();
    rd(2'd3, v);
    check("R4 fall flag", v, 16'h0010);
    wr(2'd3, 16'h0010);
    pins[4] = 1'b1;
    settle();
    rd(2'd3, v);
    check("R4 rise ignored", v, 16'h0000);

    // R5 both edges on pin 5
    msh = msh | 16'h0C00;
    wr(2'd0, msh);
    pins[5] = 1'b0;
    settle();
    rd(2'd3, v);
    check("R5 fall part", v, 16'h0020);
    wr(2'd3, 16'h0020);
    pins[5] = 1'b1;
    settle();
    rd(2'd3, v);
    check("R5 rise part", v, 16'h0020);
    wr(2'd3, 16'h0020);

    // R7 level mode pin 6
    wr(2'd2, 16'h0042);
    pins[6] = 1'b0;
    settle();
    rd(2'd3, v);
    check("R7 level flag", v, 16'h0040);
    check("R7 level irq", {8'h00, irq_req}, 16'h0040);
    wr(2'd3, 16'h0040);
    rd(2'd3, v);
    check("R7 clear no effect", v, 16'h0040);
    check("R7 irq held", {8'h00, irq_req}, 16'h0040);
    pins[6] = 1'b1;
    settle();
    check("R7 irq follows pin", {8'h00, irq_req}, 16'h0000);

    // R1 reserved position 0
    wr(2'd2, 16'h00FF);
    pins[0] = 1'b0;
    settle();
    rd(2'd3, v);
    check("R1 reserved flag", v, 16'h0000);
    check("R1 reserved irq", {8'h00, irq_req}, 16'h0000);

    // R1 reset mid-run clears everything
    wr(2'd1, 16'h00F0);
    rst_n = 1'b0;
    @(negedge clk);
    rd(2'd2, v);
    check("R1 rerst ien", v, 16'h0000);
    rd(2'd0, v);
    check("R1 rerst mode", v, 16'h0000);
    check("R1 rerst dir", {8'h00, dir_out}, 16'h0000);
    rst_n = 1'b1;
    settle();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule